// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block sequences cache maintenance work on behalf of a processor. It takes commands through a plain register-write port, turns each command into one or more per-line requests, and hands those requests to the tag/data array over a valid/ready handshake. It supports three single-line operations and an invalidate-everything command. It also supports clean and invalidate walks over a range of lines, which software arms with two writes in a row: the start address, then the end address.

The end write of a range launches the walk. The block raises `stall` toward the processor on the next cycle and keeps it high until the array has accepted the request for the last line. A line belongs to the range when its first byte address lies between start and end, both ends included. Lines are visited in ascending order. The block rejects a range whose two addresses lie in different pages, and it rejects an end write that is not directly preceded by a start write. Each rejection sets its own sticky error flag, which stays set until reset.

On the request port, `req_valid`, `req_op` and `req_addr` stay fixed while `req_ready` is low. A request completes on a rising clock edge where `req_valid` and `req_ready` are both high. The array may hold `req_ready` low for as long as it needs; the walk waits, and `stall` stays high for that time.

Top module: `crm_engine`

## Requirements
- R1: Lines are LINE_BYTES (default 32) bytes. Every request address is a line base address, with bits [4:0] equal to zero at the default size.
- R2: Write code 3 records a range start. If the very next accepted write has code 4 (clean range) or code 5 (invalidate range), it launches a walk. The walk issues exactly one request for each line whose base address B satisfies start <= B <= end, in ascending address order. The request op is 0 for a clean range and 2 for an invalidate range.
- R3: `stall` rises in the cycle after an accepted command that launches work. It falls in the cycle after the last request of that work is accepted, and it is low at all other times.
- R4: If no line base lies in [start, end], no request is issued and `stall` is high for exactly one cycle.
- R5: If start and end lie in different PAGE_BYTES pages, no request is issued, `stall` stays low, and `err_page` goes high and stays high until reset.
- R6: A code 4 or code 5 write whose preceding accepted write was not code 3 is ignored. It issues no request, does not raise `stall`, and sets `err_seq`, which stays high until reset.
- R7: Codes 0, 1 and 2 each issue one request for the line containing `wr_addr`. The request op is 0 (clean) for code 0, 1 (clean and invalidate) for code 1, and 2 (invalidate) for code 2.
- R8: Code 6 issues one request with op 3 (invalidate all) and address zero.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_op` hold their values into the next cycle.
- R10: Writes that arrive while `stall` is high are ignored and do not change the walk in progress.
- R11: After reset, `stall`, `req_valid`, `err_page` and `err_seq` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_code | input | 3 | Command code (0..6, 7 reserved and ignored) |
| wr_addr | input | AW | Address carried by the command |
| stall | output | 1 | Holds the requester while work is pending |
| err_page | output | 1 | Sticky: a range crossed a page boundary |
| err_seq | output | 1 | Sticky: a range end arrived without a start |
| req_valid | output | 1 | Maintenance request valid |
| req_ready | input | 1 | Array accepts the request |
| req_op | output | 2 | 0 clean, 1 clean-invalidate, 2 invalidate, 3 invalidate all |
| req_addr | output | AW | Line base address of the request |

## Verification
The bench builds the engine with a 16-bit address and 256-byte pages, keeping the 32-byte line. With eight lines to a page, random ranges often run over a whole page, often cross into the next one, and often round to an empty set. This makes full walks, page rejections and one-cycle empty stalls all frequent. The array side applies random back-pressure, so every walk also exercises the hold-while-waiting rule.

// File: rtl/crm_pkg.sv
package crm_pkg;
  typedef enum logic [2:0] {
    CMD_CLEAN_LINE = 3'd0,
    CMD_CINV_LINE  = 3'd1,
    CMD_INV_LINE   = 3'd2,
    CMD_RANGE_LO   = 3'd3,
    CMD_CLEAN_HI   = 3'd4,
    CMD_INV_HI     = 3'd5,
    CMD_INV_ALL    = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    OP_CLEAN   = 2'd0,
    OP_CINV    = 2'd1,
    OP_INV     = 2'd2,
    OP_INV_ALL = 2'd3
  } op_e;
endpackage

// File: rtl/crm_range.sv
module crm_range #(
  parameter int AW  = 32,
  parameter int OFS = 5,
  parameter int PGB = 12,
  localparam int LW = AW - OFS + 1
) (
  input  logic [AW-1:0]     lo_addr,
  input  logic [AW-OFS-1:0] hi_line,
  output logic [LW-1:0]     first_idx,
  output logic [LW-1:0]     last_idx,
  output logic              same_page
);
  // first line whose base is >= lo_addr; extra top bit absorbs the carry
  assign first_idx = {1'b0, lo_addr[AW-1:OFS]} + LW'(|lo_addr[OFS-1:0]);
  assign last_idx  = {1'b0, hi_line};
  assign same_page = (lo_addr[AW-1:PGB] == hi_line[AW-OFS-1:PGB-OFS]);
endmodule

// File: rtl/crm_cmd.sv
module crm_cmd
  import crm_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OFS = 5,
  parameter int PGB = 12,
  localparam int LW = AW - OFS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_code,
  input  logic [AW-1:0] wr_addr,
  input  logic          busy,
  output logic          launch,
  output op_e           launch_op,
  output logic [LW-1:0] launch_first,
  output logic [LW-1:0] launch_last,
  output logic          err_page,
  output logic          err_seq
);
  logic [AW-1:0] lo_q;
  logic          armed_q;
  logic          acc;
  logic [LW-1:0] rng_first, rng_last, own_line;
  logic          rng_same;
  logic          page_bad, seq_bad;

  crm_range #(.AW(AW), .OFS(OFS), .PGB(PGB)) u_range (
    .lo_addr  (lo_q),
    .hi_line  (wr_addr[AW-1:OFS]),
    .first_idx(rng_first),
    .last_idx (rng_last),
    .same_page(rng_same)
  );

  assign acc      = wr_en && !busy;
  assign own_line = {1'b0, wr_addr[AW-1:OFS]};

  always_comb begin
    launch       = 1'b0;
    launch_op    = OP_CLEAN;
    launch_first = own_line;
    launch_last  = own_line;
    page_bad     = 1'b0;
    seq_bad      = 1'b0;
    case (wr_code)
      CMD_CLEAN_LINE: launch = acc;
      CMD_CINV_LINE: begin launch = acc; launch_op = OP_CINV; end
      CMD_INV_LINE:  begin launch = acc; launch_op = OP_INV;  end
      CMD_INV_ALL: begin
        launch       = acc;
        launch_op    = OP_INV_ALL;
        launch_first = '0;
        launch_last  = '0;
      end
      CMD_CLEAN_HI, CMD_INV_HI: begin
        launch_op    = (wr_code == CMD_INV_HI) ? OP_INV : OP_CLEAN;
        launch_first = rng_first;
        launch_last  = rng_last;
        if (!armed_q)       seq_bad  = acc;
        else if (!rng_same) page_bad = acc;
        else                launch   = acc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      armed_q  <= 1'b0;
      err_page <= 1'b0;
      err_seq  <= 1'b0;
    end else begin
      if (acc && wr_code == CMD_RANGE_LO) begin
        lo_q    <= wr_addr;
        armed_q <= 1'b1;
      end else if (acc && wr_code != 3'd7) begin
        armed_q <= 1'b0;
      end
      if (page_bad) err_page <= 1'b1;
      if (seq_bad)  err_seq  <= 1'b1;
    end
  end

  // R6: a rejected end write never starts work in the same cycle
  a_r6_seq_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !armed_q && (wr_code == CMD_CLEAN_HI || wr_code == CMD_INV_HI)) |-> !launch);
endmodule

// File: rtl/crm_walker.sv
module crm_walker
  import crm_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OFS = 5,
  localparam int LW = AW - OFS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  op_e           launch_op,
  input  logic [LW-1:0] launch_first,
  input  logic [LW-1:0] launch_last,
  input  logic          req_ready,
  output logic          busy,
  output logic          req_valid,
  output op_e           req_op,
  output logic [AW-1:0] req_addr
);
  logic          run_q;
  logic [LW-1:0] cur_q, last_q;
  op_e           op_q;
  logic          pending;

  assign pending   = (cur_q <= last_q);
  assign busy      = run_q;
  assign req_valid = run_q && pending;
  assign req_op    = op_q;
  assign req_addr  = {cur_q[LW-2:0], {OFS{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      op_q   <= OP_CLEAN;
    end else if (launch) begin
      run_q  <= 1'b1;
      cur_q  <= launch_first;
      last_q <= launch_last;
      op_q   <= launch_op;
    end else if (run_q) begin
      if (!pending) begin
        run_q <= 1'b0;
      end else if (req_ready) begin
        if (cur_q == last_q) run_q <= 1'b0;
        else                 cur_q <= cur_q + 1'b1;
      end
    end
  end

  // R9: request held while the array back-pressures
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_op)));
  // R3: work ends only after an accepted request or an empty range
  a_r3_stall_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(!req_valid || req_ready));
endmodule

// File: rtl/crm_engine.sv
module crm_engine
  import crm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_code,
  input  logic [AW-1:0] wr_addr,
  output logic          stall,
  output logic          err_page,
  output logic          err_seq,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [1:0]    req_op,
  output logic [AW-1:0] req_addr
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int PGB = $clog2(PAGE_BYTES);
  localparam int LW  = AW - OFS + 1;

  logic          launch, busy;
  op_e           launch_op, op_w;
  logic [LW-1:0] launch_first, launch_last;

  crm_cmd #(.AW(AW), .OFS(OFS), .PGB(PGB)) u_cmd (
    .clk, .rst_n, .wr_en, .wr_code, .wr_addr, .busy,
    .launch, .launch_op, .launch_first, .launch_last,
    .err_page, .err_seq
  );

  crm_walker #(.AW(AW), .OFS(OFS)) u_walk (
    .clk, .rst_n, .launch, .launch_op, .launch_first, .launch_last,
    .req_ready, .busy, .req_valid, .req_op(op_w), .req_addr
  );

  assign stall  = busy;
  assign req_op = op_w;

  // R5: page flag is sticky and its setting write starts no work
  a_r5_page_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_page));
  a_r5_page_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_page) |-> !stall);
  // R6: sequence flag is sticky
  a_r6_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_seq));
endmodule

// File: tb/tb_crm_engine.sv
module tb_crm_engine;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_code = '0;
  logic [AW-1:0] wr_addr = '0;
  logic          req_ready = 1'b0;
  logic          stall, err_page, err_seq, req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;

  int n_run = 0;
  int n_fail = 0;
  bit exp_pg = 0;

  always #2 clk = ~clk;

  crm_engine #(.AW(AW), .LINE_BYTES(32), .PAGE_BYTES(256)) dut (
    .clk, .rst_n, .wr_en, .wr_code, .wr_addr, .stall, .err_page, .err_seq,
    .req_valid, .req_ready, .req_op, .req_addr
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] code, input logic [AW-1:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_code = code; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called on the negedge right after a launching write
  task automatic watch(input int base, input int nexp, input int op, input bit inj);
    int got = 0; int cyc = 0; bit wait_q = 0; bit last_hs = 0;
    logic [AW-1:0] hold_a = '0;
    forever begin
      if (!stall) break;
      cyc++;
      if (wait_q) chk(req_valid && req_addr == hold_a, "R9 hold", int'(req_addr), int'(hold_a));
      req_ready = ($urandom % 4) != 0;
      last_hs = 0; wait_q = 0;
      if (req_valid) begin
        if (req_ready) begin
          chk(int'(req_addr) == base + 32 * got, "R2 line address", int'(req_addr), base + 32 * got);
          chk(int'(req_op) == op, "R2 op", int'(req_op), op);
          chk(req_addr[4:0] == 5'd0, "R1 aligned", int'(req_addr[4:0]), 0);
          got++; last_hs = 1;
        end else begin
          wait_q = 1; hold_a = req_addr;
        end
      end
      if (inj) begin
        wr_en = (cyc == 1); wr_code = 3'd0; wr_addr = 16'h7777;
      end
      @(negedge clk);
      if (cyc > 3000) begin chk(0, "R3 stall stuck", cyc, 0); break; end
    end
    wr_en = 1'b0; req_ready = 1'b0;
    chk(got == nexp, inj ? "R10 lines unchanged by write" : "R2 line count", got, nexp);
    if (nexp == 0) chk(cyc == 1, "R4 one stall cycle", cyc, 1);
    else chk(last_hs, "R3 stall drop after last", 0, 1);
  endtask

  task automatic do_range(input int s, input int e, input bit inv, input bit inj);
    int fb, lb, n;
    fb = ((s + 31) / 32) * 32;
    lb = (e / 32) * 32;
    n = (lb >= fb) ? (lb - fb) / 32 + 1 : 0;
    wr(3'd3, AW'(s));
    wr(inv ? 3'd5 : 3'd4, AW'(e));
    if ((s >> 8) != (e >> 8)) begin
      exp_pg = 1;
      chk(!stall && !req_valid, "R5 no work", int'(stall), 0);
      chk(err_page == 1'b1, "R5 err_page set", int'(err_page), 1);
    end else begin
      chk(stall == 1'b1, "R3 stall rises", int'(stall), 1);
      watch(fb, n, inv ? 2 : 0, inj);
      chk(err_page == exp_pg, "R5 sticky flag", int'(err_page), int'(exp_pg));
    end
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !req_valid, "R11 reset idle", int'(stall), 0);
    chk(!err_page && !err_seq, "R11 reset flags", int'({err_page, err_seq}), 0);

    // R7 single-line ops, R1 rounding down
    wr(3'd0, 16'h1234); watch(16'h1220, 1, 0, 0);
    wr(3'd1, 16'h2A3F); watch(16'h2A20, 1, 1, 0);
    wr(3'd2, 16'hFFFF); watch(16'hFFE0, 1, 2, 0);
    // R8 invalidate all
    wr(3'd6, 16'h5555); watch(0, 1, 3, 0);

    // R2 directed ranges
    do_range(16'h0101, 16'h0160, 0, 0);
    do_range(16'h0200, 16'h0200, 1, 0);
    do_range(16'h0300, 16'h03FF, 1, 0);
    do_range(16'hFF00, 16'hFFFF, 0, 0);
    // R4 empty after rounding
    do_range(16'h0101, 16'h011F, 0, 0);
    do_range(16'h0150, 16'h0120, 1, 0);
    // R10 write during a walk
    do_range(16'h0400, 16'h04E0, 0, 1);

    // R6 end with no start, and start broken by another op
    wr(3'd4, 16'h0100);
    chk(!stall && !req_valid, "R6 ignored", int'(stall), 0);
    chk(err_seq == 1'b1, "R6 err_seq", int'(err_seq), 1);
    wr(3'd3, 16'h0600);
    wr(3'd0, 16'h0620); watch(16'h0620, 1, 0, 0);
    wr(3'd5, 16'h0660);
    chk(!stall && !req_valid, "R6 broken pair ignored", int'(stall), 0);
    chk(err_page == 1'b0, "R5 no flag yet", int'(err_page), 0);

    // R5 page crossing
    do_range(16'h00F0, 16'h0100, 0, 0);

    // random ranges
    for (int i = 0; i < 80; i++) begin
      int s, e;
      s = int'($urandom % 16'hFE00);
      e = s + int'($urandom % 300);
      do_range(s, e, $urandom % 2, 0);
    end
    chk(err_seq == 1'b1, "R6 stays set", int'(err_seq), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule